// File: doc/BRIEF.md
# Shared-Buffer Circular Queue Pointer Manager

This block keeps the read and write positions of many circular queues that are all carved out of one 32K-entry on-chip entry buffer. Software-side logic describes each queue with a descriptor: a 5-bit group that selects a 1024-entry region, and the first and last 32-entry chunk of that region that belong to the queue. The manager holds a head, a tail and an occupancy count for every queue. The storage array itself lives elsewhere. This block only turns queue operations into physical entry addresses.

A producer raises a push request with a queue number. One cycle later the block returns the physical address to write, and the tail has moved on. A consumer does the same with a pop request and gets back the address to read. Every returned address also carries its bank number. The storage is interleaved over eight banks, so back-to-back entries of one queue land in different banks. A push and a pop can both be accepted in the same cycle. Requests that cannot be served get an error pulse instead of an address.

Top module: `rpm_ring_mgr`

## Requirements
- R1: After reset every queue is empty and not full, and no ok or error pulse is given. Every descriptor is zero, so each queue is the single chunk that starts at address 0.
- R2: A descriptor write with last chunk >= first chunk installs the descriptor. It also moves both head and tail of that queue to offset 0 of the first chunk, address {group, first, 5'b0}, and empties the queue. A write with last < first is ignored, and the old descriptor and pointers remain.
- R3: An accepted push gives push_ok for one cycle, in the cycle after the request, with push_addr equal to the tail before the push. The tail then moves to the next entry.
- R4: An accepted pop gives pop_ok in the cycle after the request, with pop_addr equal to the head. Pops return addresses in the same order in which pushes wrote them.
- R5: A pointer leaving offset 31 of the last chunk goes to offset 0 of the first chunk, in the same group. Otherwise it goes to the next address.
- R6: A queue is full when its count equals (last - first + 1) * 32. A push to a full queue gives push_err in the cycle after the request, and the tail does not move.
- R7: A pop from an empty queue gives pop_err in the cycle after the request, and the head does not move.
- R8: push_bank and pop_bank equal bits 2:0 of the returned address, so successive entries of one queue use successive banks modulo 8.
- R9: A push and a pop in the same cycle are both served when their own conditions hold. When both target one queue, fullness and emptiness are judged on the count before that cycle.
- R10: When an accepted descriptor write targets the same queue as a push or pop in the same cycle, the write wins. The push or pop is refused with an error, and the queue is left empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_qid | input | QID_W | Queue addressed by the descriptor write |
| cfg_grp | input | 5 | Group (address bits 14:10) |
| cfg_first | input | 5 | First chunk of the queue |
| cfg_last | input | 5 | Last chunk of the queue |
| push_req | input | 1 | Push request |
| push_qid | input | QID_W | Queue to push |
| pop_req | input | 1 | Pop request |
| pop_qid | input | QID_W | Queue to pop |
| push_ok | output | 1 | Push accepted (one cycle after request) |
| push_err | output | 1 | Push refused |
| push_addr | output | 15 | Entry address to write |
| push_bank | output | 3 | Bank of push_addr |
| pop_ok | output | 1 | Pop accepted |
| pop_err | output | 1 | Pop refused |
| pop_addr | output | 15 | Entry address to read |
| pop_bank | output | 3 | Bank of pop_addr |
| q_full | output | NUM_Q | Per-queue full flags |
| q_empty | output | NUM_Q | Per-queue empty flags |

## Verification
The hardest case to reach from the ports is a request that arrives in the same cycle as a state change of its own queue. Examples are a push and a pop to one full or empty queue, and a descriptor write that collides with traffic to the queue it rewrites. The stimulus first fills a queue exactly to capacity, then issues the combined operations in one cycle. The scoreboard judges them against the count before that cycle. A two-chunk queue at the top of its group, and one at the very top of the buffer, drive the tail across the chunk-wrap point so that the bank sequence is checked through the wrap.

// File: rtl/rpm_pkg.sv
package rpm_pkg;
  localparam int GRP_W  = 5;
  localparam int CHK_W  = 5;
  localparam int OFF_W  = 5;
  localparam int ADDR_W = GRP_W + CHK_W + OFF_W;
  localparam int BANK_W = 3;
  localparam int CNT_W  = CHK_W + OFF_W + 1;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  typedef struct packed {
    logic [GRP_W-1:0] grp;
    logic [CHK_W-1:0] first;
    logic [CHK_W-1:0] last;
  } qdesc_t;

  function automatic addr_t ring_base(qdesc_t d);
    return {d.grp, d.first, {OFF_W{1'b0}}};
  endfunction

  function automatic addr_t ring_next(addr_t p, qdesc_t d);
    if (p[CHK_W+OFF_W-1:0] == {d.last, {OFF_W{1'b1}}})
      return ring_base(d);
    return p + addr_t'(1);
  endfunction

  function automatic cnt_t ring_cap(qdesc_t d);
    cnt_t n;
    n = cnt_t'(d.last) - cnt_t'(d.first) + cnt_t'(1);
    return n << OFF_W;
  endfunction

  function automatic logic [BANK_W-1:0] bank_of(addr_t a);
    return a[BANK_W-1:0];
  endfunction
endpackage

// File: rtl/rpm_q_slot.sv
module rpm_q_slot
  import rpm_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cfg_hit,
  input  qdesc_t cfg_desc,
  input  logic   push_hit,
  input  logic   pop_hit,
  output addr_t  head_o,
  output addr_t  tail_o,
  output logic   full_o,
  output logic   empty_o,
  output logic   push_go,
  output logic   pop_go
);
  qdesc_t desc;
  addr_t  head, tail;
  cnt_t   cnt;

  always_comb begin
    full_o  = (cnt == ring_cap(desc));
    empty_o = (cnt == '0);
    push_go = push_hit && !cfg_hit && !full_o;
    pop_go  = pop_hit  && !cfg_hit && !empty_o;
    head_o  = head;
    tail_o  = tail;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      desc <= '0;
      head <= '0;
      tail <= '0;
      cnt  <= '0;
    end else if (cfg_hit) begin
      desc <= cfg_desc;
      head <= ring_base(cfg_desc);
      tail <= ring_base(cfg_desc);
      cnt  <= '0;
    end else begin
      if (push_go) tail <= ring_next(tail, desc);
      if (pop_go)  head <= ring_next(head, desc);
      case ({push_go, pop_go})
        2'b10:   cnt <= cnt + cnt_t'(1);
        2'b01:   cnt <= cnt - cnt_t'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  // R6: occupancy never exceeds the ring capacity
  p_cap_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= ring_cap(desc));

  // R6: refused push leaves the tail in place
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push_hit && full_o && !cfg_hit |=> $stable(tail_o));

  // R7: refused pop leaves the head in place
  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop_hit && empty_o && !cfg_hit |=> $stable(head_o));

  // R2: descriptor write empties the queue and aligns the pointers
  p_cfg_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_hit |=> empty_o && (head_o == tail_o));

  // R5: tail stays inside its own chunk window
  p_tail_in_ring_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_o[ADDR_W-1 -: GRP_W] == desc.grp) &&
    (tail_o[CHK_W+OFF_W-1:OFF_W] >= desc.first) &&
    (tail_o[CHK_W+OFF_W-1:OFF_W] <= desc.last));

  // R8: each accepted push moves the tail to the next bank
  p_bank_rotate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push_go |=> tail_o[BANK_W-1:0] == $past(tail_o[BANK_W-1:0]) + 3'd1);
endmodule

// File: rtl/rpm_result_stage.sv
module rpm_result_stage
  import rpm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              go,
  input  addr_t             addr_in,
  output logic              ok,
  output logic              err,
  output addr_t             addr,
  output logic [BANK_W-1:0] bank
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ok   <= 1'b0;
      err  <= 1'b0;
      addr <= '0;
      bank <= '0;
    end else begin
      ok   <= go;
      err  <= req && !go;
      addr <= go ? addr_in : '0;
      bank <= go ? bank_of(addr_in) : '0;
    end
  end
endmodule

// File: rtl/rpm_ring_mgr.sv
module rpm_ring_mgr
  import rpm_pkg::*;
#(
  parameter int NUM_Q = 16,
  localparam int QID_W = $clog2(NUM_Q)
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [QID_W-1:0]         cfg_qid,
  input  logic [rpm_pkg::GRP_W-1:0] cfg_grp,
  input  logic [rpm_pkg::CHK_W-1:0] cfg_first,
  input  logic [rpm_pkg::CHK_W-1:0] cfg_last,
  input  logic                     push_req,
  input  logic [QID_W-1:0]         push_qid,
  input  logic                     pop_req,
  input  logic [QID_W-1:0]         pop_qid,
  output logic                     push_ok,
  output logic                     push_err,
  output logic [rpm_pkg::ADDR_W-1:0] push_addr,
  output logic [rpm_pkg::BANK_W-1:0] push_bank,
  output logic                     pop_ok,
  output logic                     pop_err,
  output logic [rpm_pkg::ADDR_W-1:0] pop_addr,
  output logic [rpm_pkg::BANK_W-1:0] pop_bank,
  output logic [NUM_Q-1:0]         q_full,
  output logic [NUM_Q-1:0]         q_empty
);
  qdesc_t cfg_desc;
  logic   cfg_valid;
  addr_t  head_a [NUM_Q];
  addr_t  tail_a [NUM_Q];
  logic [NUM_Q-1:0] push_go_a, pop_go_a, cfg_hit_a;

  // named internal events
  logic  push_go_sel, pop_go_sel;
  addr_t push_addr_sel, pop_addr_sel;

  always_comb begin
    cfg_desc  = '{grp: cfg_grp, first: cfg_first, last: cfg_last};
    cfg_valid = cfg_last >= cfg_first;
  end

  for (genvar i = 0; i < NUM_Q; i++) begin : g_slot
    assign cfg_hit_a[i] = cfg_we && cfg_valid && (cfg_qid == QID_W'(i));
    rpm_q_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_hit  (cfg_hit_a[i]),
      .cfg_desc (cfg_desc),
      .push_hit (push_req && (push_qid == QID_W'(i))),
      .pop_hit  (pop_req  && (pop_qid  == QID_W'(i))),
      .head_o   (head_a[i]),
      .tail_o   (tail_a[i]),
      .full_o   (q_full[i]),
      .empty_o  (q_empty[i]),
      .push_go  (push_go_a[i]),
      .pop_go   (pop_go_a[i])
    );
  end

  always_comb begin
    push_go_sel   = push_go_a[push_qid];
    pop_go_sel    = pop_go_a[pop_qid];
    push_addr_sel = tail_a[push_qid];
    pop_addr_sel  = head_a[pop_qid];
  end

  rpm_result_stage u_push_res (
    .clk(clk), .rst_n(rst_n), .req(push_req), .go(push_go_sel),
    .addr_in(push_addr_sel), .ok(push_ok), .err(push_err),
    .addr(push_addr), .bank(push_bank)
  );

  rpm_result_stage u_pop_res (
    .clk(clk), .rst_n(rst_n), .req(pop_req), .go(pop_go_sel),
    .addr_in(pop_addr_sel), .ok(pop_ok), .err(pop_err),
    .addr(pop_addr), .bank(pop_bank)
  );

  // R3: a push result only follows a push request
  p_push_resp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok || push_err) |-> $past(push_req));

  // R4: a pop result only follows a pop request
  p_pop_resp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok || pop_err) |-> $past(pop_req));

  // R10: a colliding descriptor write turns the push into an error
  p_cfg_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    push_req && cfg_hit_a[push_qid] |=> push_err && !push_ok);

  // R1: at most one flag per port
  p_resp_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({push_ok, push_err}) && $onehot0({pop_ok, pop_err}));
endmodule

// File: tb/sim_rpm_ring_mgr.sv
`timescale 1ns/1ps
module sim_rpm_ring_mgr;
  localparam int NQ = 16;

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic cfg_we = 0; logic [3:0] cfg_qid = 0;
  logic [4:0] cfg_grp = 0, cfg_first = 0, cfg_last = 0;
  logic push_req = 0; logic [3:0] push_qid = 0;
  logic pop_req = 0;  logic [3:0] pop_qid = 0;
  logic push_ok, push_err, pop_ok, pop_err;
  logic [14:0] push_addr, pop_addr;
  logic [2:0] push_bank, pop_bank;
  logic [NQ-1:0] q_full, q_empty;

  rpm_ring_mgr #(.NUM_Q(NQ)) u0 (
    .clk, .rst_n, .cfg_we, .cfg_qid, .cfg_grp, .cfg_first, .cfg_last,
    .push_req, .push_qid, .pop_req, .pop_qid,
    .push_ok, .push_err, .push_addr, .push_bank,
    .pop_ok, .pop_err, .pop_addr, .pop_bank, .q_full, .q_empty);

  int n_chk = 0, n_fail = 0;

  // bench model, plain integer arithmetic
  int m_grp[NQ], m_st[NQ], m_en[NQ], m_head[NQ], m_tail[NQ], m_cnt[NQ];

  typedef struct { int port; bit ok; bit err; int addr; string tag; } exp_t;
  exp_t exp_q[$];

  function automatic int cap(int q);
    return (m_en[q] - m_st[q] + 1) * 32;
  endfunction
  function automatic int step(int q, int a);
    if (a == m_grp[q]*1024 + m_en[q]*32 + 31) return m_grp[q]*1024 + m_st[q]*32;
    return a + 1;
  endfunction

  task automatic chk(bit cond, string tag, string what, int act, int expv);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // monitor: pops expectations after each edge
  always @(posedge clk) begin
    #1;
    while (exp_q.size() > 0) begin
      exp_t e; bit aok, aerr; int aa, ab;
      e = exp_q.pop_front();
      aok  = (e.port == 0) ? push_ok  : pop_ok;
      aerr = (e.port == 0) ? push_err : pop_err;
      aa   = (e.port == 0) ? int'(push_addr) : int'(pop_addr);
      ab   = (e.port == 0) ? int'(push_bank) : int'(pop_bank);
      chk(aok == e.ok && aerr == e.err, e.tag,
          (e.port == 0) ? "push ok/err" : "pop ok/err",
          int'({aok, aerr}), int'({e.ok, e.err}));
      if (e.ok) begin
        chk(aa == e.addr, e.tag, "address", aa, e.addr);
        chk(ab == e.addr % 8, "R8", "bank", ab, e.addr % 8);
      end
    end
  end

  // driver: one cycle of stimulus plus its expectations
  task automatic op(bit pe, int pq, bit oe, int oq,
                    bit ce, int cq, int cg, int cs, int cl, string tag);
    bit cv, pgo, ogo; exp_t e;
    @(negedge clk);
    push_req = pe; push_qid = 4'(pq);
    pop_req  = oe; pop_qid  = 4'(oq);
    cfg_we = ce; cfg_qid = 4'(cq); cfg_grp = 5'(cg); cfg_first = 5'(cs); cfg_last = 5'(cl);
    cv  = ce && (cl >= cs);
    pgo = pe && !(cv && cq == pq) && (m_cnt[pq] < cap(pq));
    ogo = oe && !(cv && cq == oq) && (m_cnt[oq] > 0);
    e.port = 0; e.ok = pgo; e.err = pe && !pgo; e.addr = m_tail[pq]; e.tag = tag;
    exp_q.push_back(e);
    e.port = 1; e.ok = ogo; e.err = oe && !ogo; e.addr = m_head[oq]; e.tag = tag;
    exp_q.push_back(e);
    if (pgo) begin m_tail[pq] = step(pq, m_tail[pq]); m_cnt[pq]++; end
    if (ogo) begin m_head[oq] = step(oq, m_head[oq]); m_cnt[oq]--; end
    if (cv) begin
      m_grp[cq] = cg; m_st[cq] = cs; m_en[cq] = cl;
      m_head[cq] = cg*1024 + cs*32; m_tail[cq] = m_head[cq]; m_cnt[cq] = 0;
    end
  endtask

  task automatic idle(string tag);      op(0,0,0,0,0,0,0,0,0,tag); endtask
  task automatic push1(int q, string tag); op(1,q,0,0,0,0,0,0,0,tag); endtask
  task automatic pop1(int q, string tag);  op(0,0,1,q,0,0,0,0,0,tag); endtask
  task automatic cfg1(int q, int g, int s, int l, string tag); op(0,0,0,0,1,q,g,s,l,tag); endtask

  // called right after an idle op: flags reflect the model state
  task automatic flags(int q, string tag);
    chk(q_full[q]  == (m_cnt[q] == cap(q)), tag, "q_full",  int'(q_full[q]),  int'(m_cnt[q] == cap(q)));
    chk(q_empty[q] == (m_cnt[q] == 0),      tag, "q_empty", int'(q_empty[q]), int'(m_cnt[q] == 0));
  endtask

  initial begin
    #400000;
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int q = 0; q < NQ; q++) begin
      m_grp[q] = 0; m_st[q] = 0; m_en[q] = 0; m_head[q] = 0; m_tail[q] = 0; m_cnt[q] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle("R1"); idle("R1");
    chk(q_empty == '1, "R1", "all empty", int'(q_empty), 16'hffff);
    chk(q_full == '0, "R1", "none full", int'(q_full), 0);

    // R2/R3/R6: single-chunk queue in group 2
    cfg1(0, 2, 3, 3, "R2");
    for (int i = 0; i < 32; i++) push1(0, "R3");
    idle("R6"); flags(0, "R6");
    push1(0, "R6"); push1(0, "R6");
    for (int i = 0; i < 32; i++) pop1(0, "R4");
    idle("R7"); flags(0, "R7");
    pop1(0, "R7");
    push1(0, "R5");

    // R5/R9: two chunks at the top of group 0, wrap 1023 -> 960
    cfg1(1, 0, 30, 31, "R2");
    op(1, 1, 1, 0, 0, 0, 0, 0, 0, "R9");
    for (int i = 0; i < 63; i++) push1(1, "R5");
    for (int i = 0; i < 10; i++) op(1, 2, 1, 1, 0, 0, 0, 0, 0, "R9");
    for (int i = 0; i < 10; i++) push1(1, "R5");
    idle("R6"); flags(1, "R6");

    // R9: same-queue push and pop judged on the prior count
    op(1, 1, 1, 1, 0, 0, 0, 0, 0, "R9");
    cfg1(4, 1, 0, 0, "R2");
    op(1, 4, 1, 4, 0, 0, 0, 0, 0, "R9");

    // R10: descriptor write collides with traffic to its queue
    op(1, 1, 1, 1, 1, 1, 4, 8, 9, "R10");
    idle("R10"); flags(1, "R10");
    push1(1, "R10"); pop1(1, "R10");

    // R2: rejected descriptor (last < first) leaves queue 3 as it was
    cfg1(3, 7, 5, 4, "R2");
    push1(3, "R2");
    idle("R2"); flags(3, "R2");

    // R8: top of the whole buffer, banks across the wrap
    cfg1(5, 31, 31, 31, "R2");
    for (int i = 0; i < 40; i++) op(1, 5, (i > 20), 5, 0, 0, 0, 0, 0, "R8");

    repeat (3) idle("R1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule